// File: doc/BRIEF.md
# Virtual-Processor-Tagged Translation Cache

This block is a small fully associative cache of linear-to-physical page translations. Each entry records the 16-bit virtual-processor tag that was current when it was filled, together with the linear page number and the physical frame number. Because of that tag, translations that belong to several guests and to the monitor can stay in the cache side by side across guest entry and guest exit.

The current tag is `0x0000` while the core is in monitor mode. In guest mode it is the value programmed on `guest_id`. No guest is ever given `0x0000`. A transition pulse switches between the two modes. When tagging is enabled, the transition leaves the cache untouched. When tagging is disabled, every transition empties the cache, as a cache without tags would have to. After the monitor edits a guest's page tables, it issues an invalidate-by-tag command that drops every entry of that guest. Lookups return their result one cycle after the request. The page walk and permission checks sit outside the block.

Top module: `vtag_tlb`

## Requirements
- R1: After reset, no entry is valid, `rsp_vld` is low and the block is in monitor mode.
- R2: A lookup (`lk_vld`=1) gives `rsp_vld`=1 on the next cycle. `rsp_hit` is 1 only if a valid entry matches both the current tag and `lk_vpn`, and `rsp_pfn` then carries that entry's frame. On a miss, `rsp_pfn` is 0.
- R3: The current tag used for lookups and fills is 0x0000 in monitor mode and `guest_id` in guest mode. `trans_vld` with `trans_enter`=1 enters guest mode, and with `trans_enter`=0 returns to monitor mode. A request in the same cycle as a transition uses the mode from before it.
- R4: An entry filled under one tag never hits a lookup made under a different tag.
- R5: With `tag_en`=1, a transition in either direction leaves every entry as it was.
- R6: With `tag_en`=0, a transition invalidates every entry. A fill in the same cycle is dropped.
- R7: `inv_vld` invalidates every entry whose tag equals `inv_tag` in one cycle and leaves all other entries valid.
- R8: A lookup sees the contents from before any fill, invalidate or flush in the same cycle.
- R9: A fill whose current tag and `fl_vpn` match a valid entry overwrites that entry's frame, and the replacement pointer does not advance. Any same-cycle invalidate is then overridden for that entry.
- R10: A fill that matches no entry goes to the slot at the round-robin pointer, and the pointer then advances modulo 16. The 17th distinct fill therefore evicts the oldest allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_en | input | 1 | 1 = keep entries across transitions |
| guest_id | input | 16 | Tag of the guest that runs in guest mode |
| trans_vld | input | 1 | Mode transition pulse |
| trans_enter | input | 1 | 1 = guest entry, 0 = guest exit |
| lk_vld | input | 1 | Lookup request |
| lk_vpn | input | 20 | Linear page number to look up |
| rsp_vld | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | 20 | Frame number on a hit, else 0 |
| fl_vld | input | 1 | Fill request |
| fl_vpn | input | 20 | Linear page number to fill |
| fl_pfn | input | 20 | Frame number to fill |
| inv_vld | input | 1 | Invalidate-by-tag command |
| inv_tag | input | 16 | Tag to invalidate |

## Verification
A lookup can land in the same cycle as an invalidate that removes the very entry it asks for, or as a fill of the page it asks for. The bench issues both pairs in one cycle. It expects a hit with the old frame in the first case and a miss in the second case, and on the following cycle it expects the reverse. A flushing transition is also paired with a fill, and a later lookup must show that the fill was dropped.

// File: rtl/vtag_tlb.sv
module vtag_tlb #(
  parameter int TAG_W   = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_en,
  input  logic [TAG_W-1:0] guest_id,
  input  logic             trans_vld,
  input  logic             trans_enter,
  input  logic             lk_vld,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_vld,
  output logic             rsp_hit,
  output logic [PFN_W-1:0] rsp_pfn,
  input  logic             fl_vld,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PFN_W-1:0] fl_pfn,
  input  logic             inv_vld,
  input  logic [TAG_W-1:0] inv_tag
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;
  logic               in_guest_q;

  logic [TAG_W-1:0]   cur_tag;
  logic               flush;
  logic [ENTRIES-1:0] lk_hit, fl_hit, inv_hit;
  logic               fl_match;
  logic [IDX_W-1:0]   fl_idx, wr_idx;
  logic [PFN_W-1:0]   lk_pfn;

  assign cur_tag  = in_guest_q ? guest_id : '0;
  assign flush    = trans_vld & ~tag_en;
  assign fl_match = |fl_hit;
  assign wr_idx   = fl_match ? fl_idx : rr_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_hit[i]  = vld_q[i] && tag_q[i] == cur_tag && vpn_q[i] == lk_vpn;
    assign fl_hit[i]  = vld_q[i] && tag_q[i] == cur_tag && vpn_q[i] == fl_vpn;
    assign inv_hit[i] = vld_q[i] && tag_q[i] == inv_tag;

    assert_inv_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_vld && inv_hit[i] && !fl_vld) |=> !vld_q[i]);
  end

  always_comb begin
    lk_pfn = '0;
    fl_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit[i]) lk_pfn = lk_pfn | pfn_q[i];
      if (fl_hit[i]) fl_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= '0;
      rr_q       <= '0;
      in_guest_q <= 1'b0;
      rsp_vld    <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_pfn    <= '0;
    end else begin
      rsp_vld <= lk_vld;
      rsp_hit <= lk_vld & (|lk_hit);
      rsp_pfn <= lk_vld ? lk_pfn : '0;
      if (trans_vld) in_guest_q <= trans_enter;
      if (flush) begin
        vld_q <= '0;
      end else begin
        for (int i = 0; i < ENTRIES; i++)
          if (inv_vld && inv_hit[i]) vld_q[i] <= 1'b0;
        if (fl_vld) begin
          vld_q[wr_idx] <= 1'b1;
          tag_q[wr_idx] <= cur_tag;
          vpn_q[wr_idx] <= fl_vpn;
          pfn_q[wr_idx] <= fl_pfn;
          if (!fl_match) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
      end
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vld |=> rsp_vld);
  assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_vld |=> !rsp_vld);
  assert_mode_follows_trans_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trans_vld |=> in_guest_q == $past(trans_enter));
  assert_tagged_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_vld && tag_en && !fl_vld && !inv_vld) |=> $stable(vld_q));
  assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld_q == '0);
  assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit));
  assert_rr_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_vld && !fl_match && !flush) |=> rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1));
  assert_rr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_vld && fl_match) |=> $stable(rr_q));
endmodule

// File: tb/sim_vtag_tlb.sv
module sim_vtag_tlb;
  logic        clk = 0, rst_n = 0;
  logic        tag_en = 0, trans_vld = 0, trans_enter = 0;
  logic [15:0] guest_id = 0, inv_tag = 0;
  logic        lk_vld = 0, fl_vld = 0, inv_vld = 0;
  logic [19:0] lk_vpn = 0, fl_vpn = 0, fl_pfn = 0;
  logic        rsp_vld, rsp_hit;
  logic [19:0] rsp_pfn;

  vtag_tlb u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit          m_v [16];
  logic [15:0] m_t [16];
  logic [19:0] m_vpn [16], m_pfn [16];
  int          m_rr = 0;
  bit          m_guest = 0;
  bit          q_hit [$];
  logic [19:0] q_pfn [$];
  string       q_req [$];
  string       lk_req = "";

  task automatic tick();
    logic [15:0] cur;
    int mi;
    bit eh;
    logic [19:0] ep;
    cur = m_guest ? guest_id : 16'h0;
    if (lk_vld) begin
      eh = 0; ep = 0;
      for (int i = 0; i < 16; i++)
        if (m_v[i] && m_t[i] == cur && m_vpn[i] == lk_vpn) begin eh = 1; ep = m_pfn[i]; end
      q_hit.push_back(eh); q_pfn.push_back(ep); q_req.push_back(lk_req);
    end
    if (trans_vld && !tag_en) begin
      for (int i = 0; i < 16; i++) m_v[i] = 0;
    end else begin
      mi = -1;
      for (int i = 0; i < 16; i++)
        if (m_v[i] && m_t[i] == cur && m_vpn[i] == fl_vpn) mi = i;
      if (inv_vld)
        for (int i = 0; i < 16; i++) if (m_v[i] && m_t[i] == inv_tag) m_v[i] = 0;
      if (fl_vld) begin
        if (mi < 0) begin mi = m_rr; m_rr = (m_rr + 1) % 16; end
        m_v[mi] = 1; m_t[mi] = cur; m_vpn[mi] = fl_vpn; m_pfn[mi] = fl_pfn;
      end
    end
    if (trans_vld) m_guest = trans_enter;
    @(posedge clk); @(negedge clk);
    lk_vld = 0; fl_vld = 0; inv_vld = 0; trans_vld = 0;
  endtask

  task automatic look(input logic [19:0] v, input string r);
    lk_vld = 1; lk_vpn = v; lk_req = r; tick();
  endtask
  task automatic fill(input logic [19:0] v, input logic [19:0] p);
    fl_vld = 1; fl_vpn = v; fl_pfn = p; tick();
  endtask
  task automatic trans(input bit en, input bit enter);
    trans_vld = 1; tag_en = en; trans_enter = enter; tick();
  endtask

  always @(negedge clk) if (rst_n && rsp_vld) begin
    checks++;
    if (q_hit.size() == 0) begin
      fails++; $display("FAIL R2: response with no request, hit=%0b", rsp_hit);
    end else begin
      bit eh; logic [19:0] ep; string r;
      eh = q_hit.pop_front(); ep = q_pfn.pop_front(); r = q_req.pop_front();
      if (rsp_hit !== eh || rsp_pfn !== ep) begin
        fails++;
        $display("FAIL %s: hit=%0b pfn=%h expected hit=%0b pfn=%h", r, rsp_hit, rsp_pfn, eh, ep);
      end
    end
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (rsp_vld !== 1'b0) begin fails++; $display("FAIL R1: rsp_vld=%b expected 0", rsp_vld); end
    look(20'h100, "R1");
    fill(20'h100, 20'h0AAA);
    look(20'h100, "R2");
    guest_id = 16'h0005;
    trans(1, 1);
    look(20'h100, "R4");
    fill(20'h100, 20'h0BBB);
    look(20'h100, "R3");
    trans(1, 0);
    look(20'h100, "R5");
    trans(1, 1);
    look(20'h100, "R5");
    guest_id = 16'h0007;
    look(20'h100, "R4");
    guest_id = 16'h0005;
    inv_vld = 1; inv_tag = 16'h0005; lk_vld = 1; lk_vpn = 20'h100; lk_req = "R8"; tick();
    look(20'h100, "R7");
    trans(1, 0);
    look(20'h100, "R7");
    fl_vld = 1; fl_vpn = 20'h200; fl_pfn = 20'h0C0C;
    lk_vld = 1; lk_vpn = 20'h200; lk_req = "R8"; tick();
    look(20'h200, "R8");
    fill(20'h200, 20'h0D0D);
    look(20'h200, "R9");
    for (int k = 0; k < 16; k++) fill(20'h300 + 20'(k), 20'h1000 + 20'(k));
    look(20'h200, "R10");
    look(20'h100, "R10");
    look(20'h300, "R10");
    look(20'h30F, "R10");
    trans_vld = 1; tag_en = 0; trans_enter = 0;
    fl_vld = 1; fl_vpn = 20'h400; fl_pfn = 20'h0EEE; tick();
    look(20'h300, "R6");
    look(20'h400, "R6");
    fill(20'h500, 20'h0F0F);
    trans(0, 1);
    trans(1, 0);
    look(20'h500, "R6");
    @(negedge clk); @(negedge clk);
    checks++;
    if (q_hit.size() != 0) begin fails++; $display("FAIL R2: %0d responses missing, expected 0", q_hit.size()); end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule